// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital controller of a 10-bit successive-approximation converter. Software writes a small control word that holds the power enable, the start request, the conversion clock choice, the result alignment and the interrupt enable. The block then steps a trial code, one bit at a time from the most significant bit down, and keeps or drops each bit according to a comparator input. The analog comparator is outside the block and is seen as a single digital input. When the conversion ends, the block packs the 10-bit result into two byte registers and raises a sticky completion flag. Software learns of completion by polling the busy bit or by taking the interrupt.

A hardware trigger input can start a conversion in place of software. An accepted trigger also sends a one-cycle clear pulse to a companion timer. A sleep input models the device entering its low-power state. What happens in sleep depends on the clock choice. With the internal RC clock the conversion runs on, and it ends with either a wake request or a quiet power-down. With the divided system clock, sleep aborts the conversion and powers the converter down. In both cases the enable bit still reads back as set.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, busy, enable_rb, adc_on, irq_flag, wake_req and tmr_clr are 0, and res_hi and res_lo are 0x00.
- R2: A control write (ctrl_we) with ctrl_en=1 and ctrl_go=1 sets busy in the next cycle. A write with ctrl_go=1 and ctrl_en=0 starts nothing, and busy stays 0. A write with ctrl_en=0 during a conversion stops it.
- R3: On the divided clock (ctrl_rc=0), a conversion takes 11 conversion-clock periods of CLK_DIV system cycles each: one setup period, then one trial per bit from bit 9 down to bit 0. Busy stays high for exactly 11*CLK_DIV cycles. For each trial, dac_code is the bits already kept plus the bit under trial. cmp_in=1 keeps that bit.
- R4: With ctrl_rj=1 (right alignment), res_hi = {6'b0, result[9:8]} and res_lo = result[7:0].
- R5: With ctrl_rj=0 (left alignment), res_hi = result[9:2] and res_lo = {result[1:0], 6'b0}.
- R6: Every completed conversion sets irq_flag, whatever ctrl_ie holds. The flag stays set until an irq_clr pulse clears it.
- R7: A trig_in pulse while adc_on=1 and busy=0 sets busy and pulses tmr_clr for one cycle, both in the next cycle. A trig_in pulse while busy has no effect: no tmr_clr pulse, and the conversion is not restarted.
- R8: With the RC clock (ctrl_rc=1), the start waits INSTR_CYC system cycles before the setup period. With a conversion tick on rc_tick in every cycle, busy stays high for INSTR_CYC+11 cycles.
- R9: When sleep_req is high with the divided clock selected, a running conversion is aborted in the next cycle. Busy and adc_on go to 0, enable_rb stays 1, and res_hi, res_lo and irq_flag keep their values.
- R10: On the RC clock with ctrl_ie=1, a conversion that ends during sleep sets irq_flag and pulses wake_req for one cycle. adc_on stays 1.
- R11: On the RC clock with ctrl_ie=0, a conversion that ends during sleep stores its result and sets irq_flag. It then drives adc_on to 0 while enable_rb stays 1, and it raises no wake_req.
- R12: While powered down, a start request is not accepted. A control write with ctrl_en=1 powers the converter up again, and a later start works.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_en | input | 1 | Converter enable field of the write |
| ctrl_go | input | 1 | Start request field of the write |
| ctrl_rc | input | 1 | Clock select: 1 = RC tick, 0 = divided system clock |
| ctrl_rj | input | 1 | Alignment: 1 = right, 0 = left |
| ctrl_ie | input | 1 | Completion interrupt enable |
| irq_clr | input | 1 | Clears the completion flag |
| sleep_req | input | 1 | Device is in the low-power state |
| trig_in | input | 1 | Hardware start trigger pulse |
| rc_tick | input | 1 | One-cycle tick of the RC conversion clock |
| cmp_in | input | 1 | Comparator: 1 = input at or above dac_code |
| dac_code | output | 10 | Trial code presented to the comparator |
| busy | output | 1 | Start/busy readback |
| enable_rb | output | 1 | Enable readback |
| adc_on | output | 1 | Converter powered |
| res_hi | output | 8 | High result byte |
| res_lo | output | 8 | Low result byte |
| irq_flag | output | 1 | Sticky completion flag |
| wake_req | output | 1 | One-cycle wake request |
| tmr_clr | output | 1 | One-cycle companion timer clear |

## Verification
The hardest cases to reach are the two RC-clock completions during sleep. Sleep must be raised after the start is accepted but before the last trial, and the outcome then turns on the interrupt enable alone. The bench raises sleep_req in the cycle right after the start write, while the sequencer still sits in its deferral window, and holds it until busy falls. It then reads the wake pulse count, the flag, the result and the power state. Abort with the divided clock is driven in the middle of the trials, and the result bytes from the previous conversion must survive.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEFER = 2'd1,
    ST_SETUP = 2'd2,
    ST_TRIAL = 2'd3
  } sar_state_t;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rc_sel,
  input  logic rc_tick,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CLAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic div_tick;

  assign div_tick = run && (cnt_q == CLAST);
  assign tick     = rc_sel ? (rc_tick && run) : div_tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || rc_sel)       cnt_d = '0;
    else if (cnt_q == CLAST)  cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: divided ticks are spaced CLK_DIV cycles apart
  a_r3_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (CLK_DIV > 1 && !rc_sel && tick) |=> (!tick || rc_sel));
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int NBITS     = 10,
  parameter int INSTR_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             rc_mode,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             busy,
  output logic             run,
  output logic             done,
  output logic [NBITS-1:0] final_code,
  output logic [NBITS-1:0] dac_code
);
  localparam int IW = $clog2(NBITS);
  localparam int DW = (INSTR_CYC > 1) ? $clog2(INSTR_CYC) : 1;
  localparam logic [DW-1:0] DLAST = DW'(INSTR_CYC - 1);
  localparam logic [IW-1:0] ITOP  = IW'(NBITS - 1);

  sar_state_t       st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [NBITS-1:0] sar_q, sar_d;
  logic [DW-1:0]    dcnt_q, dcnt_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    sar_d  = sar_q;
    dcnt_d = dcnt_q;
    done   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = rc_mode ? ST_DEFER : ST_SETUP;
          dcnt_d = '0;
        end
      end
      ST_DEFER: begin
        if (dcnt_q == DLAST) st_d = ST_SETUP;
        else                 dcnt_d = dcnt_q + 1'b1;
      end
      ST_SETUP: begin
        if (tick) begin
          st_d  = ST_TRIAL;
          sar_d = '0;
          idx_d = ITOP;
        end
      end
      ST_TRIAL: begin
        if (tick) begin
          sar_d[idx_q] = cmp_in;
          if (idx_q == '0) begin
            done = 1'b1;
            st_d = ST_IDLE;
          end else begin
            idx_d = idx_q - 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d = ST_IDLE;
      done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sar_q  <= '0;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      sar_q  <= sar_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign run        = (st_q == ST_SETUP) || (st_q == ST_TRIAL);
  assign final_code = sar_d;
  assign dac_code   = (st_q == ST_TRIAL) ? (sar_q | (NBITS'(1) << idx_q)) : '0;

  // R3: completion returns the sequencer to idle
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R3: the first trial after setup tests only the MSB
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP && tick && !abort) |=> (dac_code == (NBITS'(1) << (NBITS - 1))));
  // R9: an abort request empties the sequencer
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
  parameter int NBITS = 10,
  parameter int BYTE  = 8
) (
  input  logic [NBITS-1:0] code,
  input  logic             rj,
  output logic [BYTE-1:0]  hi,
  output logic [BYTE-1:0]  lo
);
  localparam int TOT = 2 * BYTE;
  localparam int PAD = TOT - NBITS;

  logic [TOT-1:0] right_v, left_v, pick_v;

  assign right_v = {{PAD{1'b0}}, code};
  assign left_v  = {code, {PAD{1'b0}}};
  assign pick_v  = rj ? right_v : left_v;
  assign hi      = pick_v[TOT-1:BYTE];
  assign lo      = pick_v[BYTE-1:0];
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int NBITS     = 10,
  parameter int BYTE      = 8,
  parameter int CLK_DIV   = 4,
  parameter int INSTR_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             ctrl_en,
  input  logic             ctrl_go,
  input  logic             ctrl_rc,
  input  logic             ctrl_rj,
  input  logic             ctrl_ie,
  input  logic             irq_clr,
  input  logic             sleep_req,
  input  logic             trig_in,
  input  logic             rc_tick,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic             busy,
  output logic             enable_rb,
  output logic             adc_on,
  output logic [BYTE-1:0]  res_hi,
  output logic [BYTE-1:0]  res_lo,
  output logic             irq_flag,
  output logic             wake_req,
  output logic             tmr_clr
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic en_q, rc_q, rj_q, ie_q;
  logic pwr_dn_q, pwr_dn_d;
  logic irq_q, irq_d;
  logic wake_q, wake_d;
  logic tclr_q, tclr_d;
  logic [BYTE-1:0] hi_q, hi_d, lo_q, lo_d;

  logic rc_eff, abort, sw_start, trig_ok, start;
  logic eng_busy, eng_run, eng_done, tick;
  logic [NBITS-1:0] final_code;
  logic [BYTE-1:0]  fmt_hi, fmt_lo;
  logic pd_set, pd_clr;

  assign rc_eff   = ctrl_we ? ctrl_rc : rc_q;
  assign adc_on   = en_q && !pwr_dn_q;
  assign abort    = (sleep_req && !rc_eff) || (ctrl_we && !ctrl_en);
  assign sw_start = ctrl_we && ctrl_en && ctrl_go && !pwr_dn_q;
  assign trig_ok  = trig_in && adc_on && !eng_busy && !abort;
  assign start    = (sw_start || trig_ok) && !eng_busy && !abort;

  sar_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (srst_n),
    .run    (eng_run),
    .rc_sel (rc_q),
    .rc_tick(rc_tick),
    .tick   (tick)
  );

  sar_engine #(.NBITS(NBITS), .INSTR_CYC(INSTR_CYC)) u_eng (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (start),
    .abort     (abort),
    .rc_mode   (rc_eff),
    .tick      (tick),
    .cmp_in    (cmp_in),
    .busy      (eng_busy),
    .run       (eng_run),
    .done      (eng_done),
    .final_code(final_code),
    .dac_code  (dac_code)
  );

  sar_fmt #(.NBITS(NBITS), .BYTE(BYTE)) u_fmt (
    .code(final_code),
    .rj  (rj_q),
    .hi  (fmt_hi),
    .lo  (fmt_lo)
  );

  always_comb begin
    pd_set   = (sleep_req && !rc_eff && (en_q || (ctrl_we && ctrl_en)))
             || (eng_done && sleep_req && !ie_q);
    pd_clr   = ctrl_we && ctrl_en;
    pwr_dn_d = pwr_dn_q;
    if (pd_set)      pwr_dn_d = 1'b1;
    else if (pd_clr) pwr_dn_d = 1'b0;

    irq_d = irq_q;
    if (eng_done)     irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;

    wake_d = eng_done && sleep_req && ie_q;
    tclr_d = trig_ok;

    hi_d = hi_q;
    lo_d = lo_q;
    if (eng_done) begin
      hi_d = fmt_hi;
      lo_d = fmt_lo;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q <= 1'b0;
      rc_q <= 1'b0;
      rj_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q <= ctrl_en;
      rc_q <= ctrl_rc;
      rj_q <= ctrl_rj;
      ie_q <= ctrl_ie;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pwr_dn_q <= 1'b0;
      irq_q    <= 1'b0;
      wake_q   <= 1'b0;
      tclr_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      pwr_dn_q <= pwr_dn_d;
      irq_q    <= irq_d;
      wake_q   <= wake_d;
      tclr_q   <= tclr_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
    end
  end

  assign busy      = eng_busy;
  assign enable_rb = en_q;
  assign res_hi    = hi_q;
  assign res_lo    = lo_q;
  assign irq_flag  = irq_q;
  assign wake_req  = wake_q;
  assign tmr_clr   = tclr_q;

  // R7: a timer clear only accompanies a conversion that was started
  a_r7_clr_with_busy: assert property (@(posedge clk) disable iff (!srst_n)
    tmr_clr |-> busy);
  // R10: a wake request always comes with the completion flag
  a_r10_wake_flag: assert property (@(posedge clk) disable iff (!srst_n)
    wake_req |-> irq_flag);
  // R12: an unpowered converter never sequences
  a_r12_off_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !adc_on |-> !busy);
  // R11: power-down keeps the enable bit set
  a_r11_enable_kept: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(pwr_dn_q) |-> enable_rb);
endmodule

// File: tb/sar_seq_top_bench.sv
`timescale 1ns/1ps
module sar_seq_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 0, ctrl_en = 0, ctrl_go = 0, ctrl_rc = 0, ctrl_rj = 0, ctrl_ie = 0;
  logic irq_clr = 0, sleep_req = 0, trig_in = 0, rc_tick = 0;
  logic cmp_in;
  logic [9:0] dac_code;
  logic busy, enable_rb, adc_on, irq_flag, wake_req, tmr_clr;
  logic [7:0] res_hi, res_lo;

  logic [9:0] vin = 10'd0;
  bit rc_always = 1'b0;
  int tests = 0, fails = 0, cyc = 0, wake_cnt = 0;

  always #2 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  sar_seq_top u_sar_seq_top (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_go(ctrl_go),
    .ctrl_rc(ctrl_rc), .ctrl_rj(ctrl_rj), .ctrl_ie(ctrl_ie), .irq_clr(irq_clr),
    .sleep_req(sleep_req), .trig_in(trig_in), .rc_tick(rc_tick), .cmp_in(cmp_in),
    .dac_code(dac_code), .busy(busy), .enable_rb(enable_rb), .adc_on(adc_on),
    .res_hi(res_hi), .res_lo(res_lo), .irq_flag(irq_flag), .wake_req(wake_req),
    .tmr_clr(tmr_clr)
  );

  always @(negedge clk) rc_tick <= rc_always ? 1'b1 : 1'($urandom_range(1, 0));
  always @(posedge clk) if (wake_req) wake_cnt <= wake_cnt + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  function automatic logic [7:0] exp_hi(input logic [9:0] v, input bit rj);
    return rj ? {6'b0, v[9:8]} : v[9:2];
  endfunction
  function automatic logic [7:0] exp_lo(input logic [9:0] v, input bit rj);
    return rj ? v[7:0] : {v[1:0], 6'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit go, input bit rc, input bit rj, input bit ie);
    @(negedge clk);
    ctrl_we = 1; ctrl_en = en; ctrl_go = go; ctrl_rc = rc; ctrl_rj = rj; ctrl_ie = ie;
    @(negedge clk);
    ctrl_we = 0; ctrl_go = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  int n;
  int tc;
  logic [7:0] old_hi, old_lo;

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 0 && enable_rb == 0 && adc_on == 0, "R1 ctl", {busy, enable_rb, adc_on}, 0);
    chk(irq_flag == 0 && wake_req == 0 && tmr_clr == 0, "R1 flags", {irq_flag, wake_req, tmr_clr}, 0);
    chk(res_hi == 0 && res_lo == 0, "R1 result", {res_hi, res_lo}, 0);

    // R2 go without enable is ignored
    wr(0, 1, 0, 1, 0);
    @(negedge clk);
    chk(busy == 0, "R2 go without enable", busy, 0);

    // R2/R3/R4/R6 software start, divided clock, right alignment
    wr(1, 0, 0, 1, 0);
    vin = 10'h2A5;
    wr(1, 1, 0, 1, 0);
    chk(busy == 1, "R2 busy after start", busy, 1);
    busy_len(n);
    chk(n == 44, "R3 conversion length", n, 44);
    chk(res_hi == exp_hi(vin, 1), "R4 hi", res_hi, exp_hi(vin, 1));
    chk(res_lo == exp_lo(vin, 1), "R4 lo", res_lo, exp_lo(vin, 1));
    chk(irq_flag == 1, "R6 flag set without ie", irq_flag, 1);
    repeat (3) @(negedge clk);
    chk(irq_flag == 1, "R6 flag sticky", irq_flag, 1);
    pulse_clr();
    chk(irq_flag == 0, "R6 flag cleared", irq_flag, 0);

    // R5 left alignment
    wr(1, 1, 0, 0, 0);
    busy_len(n);
    chk(res_hi == 8'hA9, "R5 hi", res_hi, 8'hA9);
    chk(res_lo == 8'h40, "R5 lo", res_lo, 8'h40);
    pulse_clr();

    // R2 disabling mid-conversion stops it
    wr(1, 1, 0, 1, 0);
    repeat (6) @(negedge clk);
    wr(0, 0, 0, 1, 0);
    chk(busy == 0 && irq_flag == 0, "R2 stop by disable", {busy, irq_flag}, 0);
    wr(1, 0, 0, 1, 0);

    // R7 trigger start, then ignored trigger while busy
    vin = 10'h13C;
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
    chk(busy == 1 && tmr_clr == 1, "R7 trigger accepted", {busy, tmr_clr}, 2'b11);
    n = 0; tc = 0;
    while (busy && n < 5000) begin
      n++;
      if (tmr_clr) tc++;
      if (n == 8) trig_in = 1;
      else trig_in = 0;
      @(negedge clk);
    end
    trig_in = 0;
    chk(tc == 1, "R7 busy trigger gives no timer clear", tc, 1);
    chk(n == 44, "R7 busy trigger no restart", n, 44);
    chk(res_lo == 8'h3C && res_hi == 8'h01, "R7 result", {res_hi, res_lo}, 16'h013C);
    pulse_clr();

    // R8 RC clock deferral
    rc_always = 1;
    vin = 10'h3FF;
    wr(1, 1, 1, 1, 0);
    busy_len(n);
    chk(n == 15, "R8 deferred length", n, 15);
    chk(res_hi == 8'h03 && res_lo == 8'hFF, "R8 result", {res_hi, res_lo}, 16'h03FF);
    pulse_clr();

    // R9 sleep with divided clock aborts
    old_hi = res_hi; old_lo = res_lo;
    vin = 10'h055;
    wr(1, 1, 0, 1, 1);
    repeat (10) @(negedge clk);
    sleep_req = 1;
    @(negedge clk);
    chk(busy == 0 && adc_on == 0, "R9 abort powers down", {busy, adc_on}, 0);
    chk(enable_rb == 1, "R9 enable kept", enable_rb, 1);
    chk(res_hi == old_hi && res_lo == old_lo && irq_flag == 0, "R9 result and flag kept",
        {res_hi, res_lo, 7'd0, irq_flag}, {old_hi, old_lo, 8'd0});
    sleep_req = 0;

    // R12 powered down start ignored, write re-arms
    @(negedge clk);
    wr(1, 1, 0, 1, 0);
    chk(busy == 0 && adc_on == 1, "R12 re-arm without start", {busy, adc_on}, 2'b01);
    wr(1, 1, 0, 1, 0);
    chk(busy == 1, "R12 start after re-arm", busy, 1);
    busy_len(n);
    chk(res_lo == 8'h55, "R12 result", res_lo, 8'h55);
    pulse_clr();

    // R10 RC clock, sleep with interrupt enabled wakes
    rc_always = 0;
    vin = 10'h2C3;
    tc = wake_cnt;
    wr(1, 1, 1, 0, 1);
    sleep_req = 1;
    busy_len(n);
    @(negedge clk);
    chk(wake_cnt == tc + 1, "R10 one wake pulse", wake_cnt - tc, 1);
    chk(irq_flag == 1 && adc_on == 1, "R10 flag and power", {irq_flag, adc_on}, 2'b11);
    chk(res_hi == exp_hi(vin, 0) && res_lo == exp_lo(vin, 0), "R10 result",
        {res_hi, res_lo}, {exp_hi(vin, 0), exp_lo(vin, 0)});
    sleep_req = 0;
    pulse_clr();

    // R11 RC clock, sleep without interrupt powers down quietly
    vin = 10'h0F7;
    tc = wake_cnt;
    wr(1, 1, 1, 1, 0);
    sleep_req = 1;
    busy_len(n);
    @(negedge clk);
    chk(adc_on == 0 && enable_rb == 1, "R11 quiet power-down", {adc_on, enable_rb}, 2'b01);
    chk(wake_cnt == tc && irq_flag == 1, "R11 no wake, flag set", {wake_cnt - tc, irq_flag}, 1);
    chk(res_hi == 8'h00 && res_lo == 8'hF7, "R11 result", {res_hi, res_lo}, 16'h00F7);
    sleep_req = 0;
    pulse_clr();
    wr(1, 0, 0, 1, 0);

    // R3/R4/R5 random conversions across modes
    for (int i = 0; i < 24; i++) begin
      bit rj, rc;
      vin = 10'($urandom_range(1023, 0));
      rj = 1'($urandom_range(1, 0));
      rc = 1'($urandom_range(1, 0));
      wr(1, 1, rc, rj, 0);
      busy_len(n);
      chk(res_hi == exp_hi(vin, rj) && res_lo == exp_lo(vin, rj), "R3 random result",
          {res_hi, res_lo}, {exp_hi(vin, rj), exp_lo(vin, rj)});
      chk(irq_flag == 1, "R6 random flag", irq_flag, 1);
      pulse_clr();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule